// File: doc/BRIEF.md
# Sharing-List Cache Line Controller

This block is the per-line coherence engine of one cache node in a directory scheme where the caches holding a line are chained into a doubly linked list. Each node keeps two node-ID pointers. The up pointer leads toward the newest member, which is the head. The down pointer leads toward older members. A node joins by asking memory for the line. Memory answers with the ID of the previous newest member. The node then sends an attach message to that member, which records the newcomer and hands it the head role in its reply. The head role therefore moves in the order in which nodes reached memory.

Only the head may make the line writable. Before it does, it walks down the list one member at a time. It sends each member an invalidate, and each member answers with its own down pointer. A member that wants to write, or whose entry is being replaced, first unlinks itself by telling its two neighbours about each other. A writer then asks memory for the line again. A dirty head that is evicted writes the line back before it unlinks.

Packets are abstracted as valid/ready ports that carry a type, a source ID, a destination ID and one pointer field. ID 0 is the null pointer.

Top module: `sharing_line_ctrl`

## Requirements
- R1: After reset the line is invalid: `tx_valid`, `rd_ok`, `wr_ok` and `head_o` are all low.
- R2: A read or write request (`cpu_rd` or `cpu_wr`) on an invalid line sends a memory request (type 0) to `MEM_ID`. Read permission stays off until the line is obtained.
- R3: A memory reply (type 1) whose pointer is null makes the node head with a clean line: `rd_ok` and `head_o` go high and `wr_ok` stays low.
- R4: A memory reply with a non-null pointer makes the node send an attach (type 2) to that node. While it waits for the attach reply, `rd_ok` is high and `wr_ok` is low. An attach reply (type 3) makes it head.
- R5: A head that receives an attach answers the sender with an attach reply and then becomes an ordinary sharer. It loses `head_o` and `wr_ok` and keeps `rd_ok`.
- R6: A sharer that receives an invalidate (type 4) answers with an invalidate reply (type 5) whose pointer is its down pointer, and drops `rd_ok`. Its next access sends a new memory request.
- R7: A write request on a clean head starts a walk. It sends an invalidate to its down neighbour, then one to each non-null pointer returned. When a null pointer is returned, `wr_ok` goes high. With no down neighbour, `wr_ok` rises without any packet.
- R8: A request packet (attach, invalidate, set-down type 6, set-up type 7) that is illegal in the current state is answered with a retry (type 9, pointer 0) to its sender. A retry received while waiting for a reply makes the node send its last request again.
- R9: A write request on a sharer unlinks it first. It sends a set-down to its up neighbour carrying its down pointer, then a set-up to its down neighbour carrying its up pointer. A neighbour that is null is skipped. Each of these waits for an unlink reply (type 8). The node then sends a new memory request.
- R10: Eviction (`cpu_evict`) of a shared or clean line runs the same unlink and leaves the line invalid. A dirty head first sends a write-back (type 10) to `MEM_ID`.
- R11: A received set-down replaces the down pointer and a received set-up replaces the up pointer. Each is answered with an unlink reply. A set-up carrying null makes a sharer head.
- R12: A packet whose destination is not `NODE_ID` is consumed with no reply and no change of state.
- R13: An offered packet holds its fields until `tx_ready`. `rx_ready` is low while a packet is offered. No packet is addressed to ID 0 or to the node itself.
- R14: `wr_ok` is only ever high together with `head_o` and `rd_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Processor wants to read the line |
| cpu_wr | input | 1 | Processor wants to write the line |
| cpu_evict | input | 1 | Cache entry is being replaced |
| rd_ok | output | 1 | Line data may be read |
| wr_ok | output | 1 | Line may be written |
| head_o | output | 1 | Node holds the head role |
| rx_valid | input | 1 | Incoming packet valid |
| rx_ready | output | 1 | Incoming packet accepted |
| rx_type | input | 4 | Incoming packet type |
| rx_src | input | ID_W | Incoming packet sender |
| rx_dst | input | ID_W | Incoming packet destination |
| rx_ptr | input | ID_W | Incoming pointer field |
| tx_valid | output | 1 | Outgoing packet valid |
| tx_ready | input | 1 | Outgoing packet taken |
| tx_type | output | 4 | Outgoing packet type |
| tx_src | output | ID_W | Outgoing sender, always NODE_ID |
| tx_dst | output | ID_W | Outgoing destination |
| tx_ptr | output | ID_W | Outgoing pointer field |

## Verification
An accepted packet changes `rd_ok`, `wr_ok` and `head_o` one edge after the accepting edge. Its reply appears on `tx_valid` in that same cycle. A request the node makes on its own follows one edge after the state that causes it is entered. The bench therefore drives every input at a falling edge and reads the outputs at the next falling edge. When it waits for an outgoing packet, it polls `tx_valid` at falling edges within a short bound and only then raises `tx_ready` for exactly one edge. Each state is reached by a scripted series of packets that plays the neighbour nodes and memory. The permissions and every field of the outgoing packets are compared with values worked out from the requirements.

// File: rtl/sl_pkg.sv
package sl_pkg;

  typedef enum logic [3:0] {
    MSG_MREQ  = 4'd0,
    MSG_MRSP  = 4'd1,
    MSG_ATT   = 4'd2,
    MSG_ATTR  = 4'd3,
    MSG_INV   = 4'd4,
    MSG_INVR  = 4'd5,
    MSG_SETDN = 4'd6,
    MSG_SETUP = 4'd7,
    MSG_UNLR  = 4'd8,
    MSG_RETRY = 4'd9,
    MSG_WB    = 4'd10
  } msg_e;

  typedef enum logic [3:0] {
    LS_INVALID, LS_MREQ, LS_MWAIT, LS_ATT, LS_PENDING,
    LS_SHARED, LS_HCLEAN, LS_HDIRTY, LS_INVSEND, LS_INVWAIT,
    LS_WB, LS_LUP, LS_LUPW, LS_LDN, LS_LDNW
  } lstate_e;

  function automatic logic msg_is_request(msg_e t);
    return (t == MSG_ATT) || (t == MSG_INV) || (t == MSG_SETDN) || (t == MSG_SETUP);
  endfunction

endpackage

// File: rtl/sl_rst_sync.sv
module sl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sl_id_reg.sv
module sl_id_reg #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [ID_W-1:0] d,
  output logic [ID_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/sl_reply_buf.sv
module sl_reply_buf #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [3:0]      ld_type,
  input  logic [ID_W-1:0] ld_dst,
  input  logic [ID_W-1:0] ld_ptr,
  input  logic            take,
  output logic            valid_q,
  output logic [3:0]      type_q,
  output logic [ID_W-1:0] dst_q,
  output logic [ID_W-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      type_q  <= '0;
      dst_q   <= '0;
      ptr_q   <= '0;
    end else if (take) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      type_q  <= ld_type;
      dst_q   <= ld_dst;
      ptr_q   <= ld_ptr;
    end
  end
endmodule

// File: rtl/sharing_line_ctrl.sv
module sharing_line_ctrl #(
  parameter int ID_W    = 4,
  parameter int NODE_ID = 1,
  parameter int MEM_ID  = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_rd,
  input  logic            cpu_wr,
  input  logic            cpu_evict,
  output logic            rd_ok,
  output logic            wr_ok,
  output logic            head_o,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [3:0]      rx_type,
  input  logic [ID_W-1:0] rx_src,
  input  logic [ID_W-1:0] rx_dst,
  input  logic [ID_W-1:0] rx_ptr,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [3:0]      tx_type,
  output logic [ID_W-1:0] tx_src,
  output logic [ID_W-1:0] tx_dst,
  output logic [ID_W-1:0] tx_ptr
);
  import sl_pkg::*;

  localparam logic [ID_W-1:0] NULL_ID = '0;
  localparam logic [ID_W-1:0] SELF_ID = ID_W'(NODE_ID);
  localparam logic [ID_W-1:0] MEM_PTR = ID_W'(MEM_ID);

  logic            rst_i_n;
  lstate_e         st_q, st_n;
  logic            rejoin_q, rejoin_n;
  logic            up_ld, dn_ld, walk_ld;
  logic [ID_W-1:0] up_d, dn_d, walk_d, up_q, dn_q, walk_q;
  logic            rb_ld, rb_v;
  logic [3:0]      rb_ld_type, rb_type;
  logic [ID_W-1:0] rb_ld_ptr, rb_dst, rb_ptr;
  logic            own_send, own_fire, rx_fire, rx_mine;
  msg_e            own_type, rx_msg;
  logic [ID_W-1:0] own_dst, own_ptr;

  sl_rst_sync rst_i (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  sl_id_reg #(.ID_W(ID_W)) up_reg_i   (.clk(clk), .rst_n(rst_i_n), .ld(up_ld),   .d(up_d),   .q(up_q));
  sl_id_reg #(.ID_W(ID_W)) dn_reg_i   (.clk(clk), .rst_n(rst_i_n), .ld(dn_ld),   .d(dn_d),   .q(dn_q));
  sl_id_reg #(.ID_W(ID_W)) walk_reg_i (.clk(clk), .rst_n(rst_i_n), .ld(walk_ld), .d(walk_d), .q(walk_q));

  sl_reply_buf #(.ID_W(ID_W)) rbuf_i (
    .clk(clk), .rst_n(rst_i_n), .load(rb_ld), .ld_type(rb_ld_type), .ld_dst(rx_src),
    .ld_ptr(rb_ld_ptr), .take(rb_v && tx_ready), .valid_q(rb_v), .type_q(rb_type),
    .dst_q(rb_dst), .ptr_q(rb_ptr)
  );

  // Requests this node originates, one per sending state
  always_comb begin
    own_send = 1'b1;
    own_type = MSG_MREQ;
    own_dst  = MEM_PTR;
    own_ptr  = NULL_ID;
    unique case (st_q)
      LS_MREQ:    ;
      LS_ATT:     begin own_type = MSG_ATT;   own_dst = dn_q;   end
      LS_INVSEND: begin own_type = MSG_INV;   own_dst = walk_q; end
      LS_WB:      own_type = MSG_WB;
      LS_LUP:     begin own_type = MSG_SETDN; own_dst = up_q; own_ptr = dn_q; end
      LS_LDN:     begin own_type = MSG_SETUP; own_dst = dn_q; own_ptr = up_q; end
      default:    own_send = 1'b0;
    endcase
  end

  // Replies take precedence; incoming packets wait while anything is offered
  assign tx_valid = rb_v || own_send;
  assign tx_type  = rb_v ? rb_type : own_type;
  assign tx_dst   = rb_v ? rb_dst  : own_dst;
  assign tx_ptr   = rb_v ? rb_ptr  : own_ptr;
  assign tx_src   = SELF_ID;
  assign rx_ready = !rb_v && !own_send;
  assign rx_fire  = rx_valid && rx_ready;
  assign rx_mine  = rx_fire && (rx_dst == SELF_ID);
  assign own_fire = own_send && !rb_v && tx_ready;
  assign rx_msg   = msg_e'(rx_type);

  function automatic lstate_e leave_from(logic [ID_W-1:0] up, logic [ID_W-1:0] dn, logic rj);
    if (up != NULL_ID)      return LS_LUP;
    else if (dn != NULL_ID) return LS_LDN;
    else                    return rj ? LS_MREQ : LS_INVALID;
  endfunction

  always_comb begin
    st_n       = st_q;
    rejoin_n   = rejoin_q;
    up_ld      = 1'b0; up_d   = rx_ptr;
    dn_ld      = 1'b0; dn_d   = rx_ptr;
    walk_ld    = 1'b0; walk_d = rx_ptr;
    rb_ld      = rx_mine && msg_is_request(rx_msg);
    rb_ld_type = MSG_RETRY;
    rb_ld_ptr  = NULL_ID;
    if (rx_mine) begin
      unique case (rx_msg)
        MSG_ATT: if (st_q == LS_HCLEAN || st_q == LS_HDIRTY) begin
          up_ld = 1'b1; up_d = rx_src; st_n = LS_SHARED; rb_ld_type = MSG_ATTR;
        end
        MSG_INV: if (st_q == LS_SHARED) begin
          st_n = LS_INVALID; rb_ld_type = MSG_INVR; rb_ld_ptr = dn_q;
        end
        MSG_SETDN: if (st_q == LS_SHARED || st_q == LS_HCLEAN || st_q == LS_HDIRTY) begin
          dn_ld = 1'b1; rb_ld_type = MSG_UNLR;
        end
        MSG_SETUP: if (st_q == LS_SHARED) begin
          up_ld = 1'b1; rb_ld_type = MSG_UNLR;
          if (rx_ptr == NULL_ID) st_n = LS_HCLEAN;
        end
        MSG_MRSP: if (st_q == LS_MWAIT) begin
          up_ld = 1'b1; up_d = NULL_ID; dn_ld = 1'b1;
          st_n = (rx_ptr == NULL_ID) ? LS_HCLEAN : LS_ATT;
        end
        MSG_ATTR: if (st_q == LS_PENDING) st_n = LS_HCLEAN;
        MSG_INVR: if (st_q == LS_INVWAIT) begin
          if (rx_ptr == NULL_ID) begin dn_ld = 1'b1; st_n = LS_HDIRTY; end
          else begin walk_ld = 1'b1; st_n = LS_INVSEND; end
        end
        MSG_UNLR: begin
          if (st_q == LS_LUPW)
            st_n = (dn_q != NULL_ID) ? LS_LDN : (rejoin_q ? LS_MREQ : LS_INVALID);
          else if (st_q == LS_LDNW)
            st_n = rejoin_q ? LS_MREQ : LS_INVALID;
        end
        MSG_RETRY: begin
          if (st_q == LS_PENDING) st_n = LS_ATT;
          else if (st_q == LS_INVWAIT) st_n = LS_INVSEND;
          else if (st_q == LS_LUPW) st_n = LS_LUP;
          else if (st_q == LS_LDNW) st_n = LS_LDN;
        end
        default: ;
      endcase
    end else if (own_fire) begin
      unique case (st_q)
        LS_MREQ:    st_n = LS_MWAIT;
        LS_ATT:     st_n = LS_PENDING;
        LS_INVSEND: st_n = LS_INVWAIT;
        LS_WB:      st_n = leave_from(up_q, dn_q, rejoin_q);
        LS_LUP:     st_n = LS_LUPW;
        LS_LDN:     st_n = LS_LDNW;
        default:    ;
      endcase
    end else if (!rx_fire) begin
      unique case (st_q)
        LS_INVALID: if (cpu_rd || cpu_wr) st_n = LS_MREQ;
        LS_SHARED: begin
          if (cpu_evict) begin rejoin_n = 1'b0; st_n = leave_from(up_q, dn_q, 1'b0); end
          else if (cpu_wr) begin rejoin_n = 1'b1; st_n = leave_from(up_q, dn_q, 1'b1); end
        end
        LS_HCLEAN: begin
          if (cpu_evict) begin rejoin_n = 1'b0; st_n = leave_from(up_q, dn_q, 1'b0); end
          else if (cpu_wr) begin
            if (dn_q == NULL_ID) st_n = LS_HDIRTY;
            else begin walk_ld = 1'b1; walk_d = dn_q; st_n = LS_INVSEND; end
          end
        end
        LS_HDIRTY: if (cpu_evict) begin rejoin_n = 1'b0; st_n = LS_WB; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q     <= LS_INVALID;
      rejoin_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      rejoin_q <= rejoin_n;
    end
  end

  assign head_o = (st_q == LS_HCLEAN) || (st_q == LS_HDIRTY) ||
                  (st_q == LS_INVSEND) || (st_q == LS_INVWAIT);
  assign rd_ok  = head_o || (st_q == LS_SHARED) || (st_q == LS_ATT) || (st_q == LS_PENDING);
  assign wr_ok  = (st_q == LS_HDIRTY);

endmodule

// File: rtl/sharing_line_ctrl_chk.sv
module sharing_line_ctrl_chk #(
  parameter int ID_W    = 4,
  parameter int NODE_ID = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_ok,
  input logic            wr_ok,
  input logic            head_o,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic [3:0]      rx_type,
  input logic [ID_W-1:0] rx_dst,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [3:0]      tx_type,
  input logic [ID_W-1:0] tx_dst,
  input logic [ID_W-1:0] tx_ptr
);
  assert_write_needs_head_R14: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (head_o && rd_ok));

  assert_tx_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_type) && $stable(tx_dst) && $stable(tx_ptr)));

  assert_rx_blocked_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

  assert_dst_named_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_dst != '0 && tx_dst != ID_W'(NODE_ID)));

  assert_attach_drops_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_dst == ID_W'(NODE_ID) && rx_type == 4'd2 && wr_ok) |=> !wr_ok);
endmodule

bind sharing_line_ctrl sharing_line_ctrl_chk #(.ID_W(ID_W), .NODE_ID(NODE_ID)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_ok(rd_ok), .wr_ok(wr_ok), .head_o(head_o),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_type(rx_type), .rx_dst(rx_dst),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_type(tx_type), .tx_dst(tx_dst), .tx_ptr(tx_ptr)
);

// File: tb/sharing_line_ctrl_tb_top.sv
module sharing_line_ctrl_tb_top;
  localparam int ID_W = 4;
  localparam int NODE = 1;
  localparam int MEM  = 15;
  // type codes taken from the requirements
  localparam int T_MREQ = 0, T_MRSP = 1, T_ATT = 2, T_ATTR = 3, T_INV = 4, T_INVR = 5;
  localparam int T_SETDN = 6, T_SETUP = 7, T_UNLR = 8, T_RETRY = 9, T_WB = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_rd, cpu_wr, cpu_evict;
  logic rd_ok, wr_ok, head_o;
  logic rx_valid, rx_ready;
  logic [3:0] rx_type;
  logic [ID_W-1:0] rx_src, rx_dst, rx_ptr;
  logic tx_valid, tx_ready;
  logic [3:0] tx_type;
  logic [ID_W-1:0] tx_src, tx_dst, tx_ptr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sharing_line_ctrl #(.ID_W(ID_W), .NODE_ID(NODE), .MEM_ID(MEM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_evict(cpu_evict),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .head_o(head_o),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_type(rx_type), .rx_src(rx_src),
    .rx_dst(rx_dst), .rx_ptr(rx_ptr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_type(tx_type), .tx_src(tx_src),
    .tx_dst(tx_dst), .tx_ptr(tx_ptr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic perm(input string req, input int rd, input int wr, input int hd);
    chk(req, "rd_ok", int'(rd_ok), rd);
    chk(req, "wr_ok", int'(wr_ok), wr);
    chk(req, "head_o", int'(head_o), hd);
  endtask

  task automatic send(input string req, input int typ, input int src, input int ptr, input int dst = NODE);
    chk(req, "rx_ready before send", int'(rx_ready), 1);
    rx_valid = 1'b1;
    rx_type  = 4'(typ);
    rx_src   = ID_W'(src);
    rx_dst   = ID_W'(dst);
    rx_ptr   = ID_W'(ptr);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_tx(input string req, input int typ, input int dst, input int ptr);
    for (int w = 0; w < 6 && !tx_valid; w++) @(negedge clk);
    chk(req, "tx_valid", int'(tx_valid), 1);
    chk(req, "tx_type", int'(tx_type), typ);
    chk(req, "tx_dst", int'(tx_dst), dst);
    chk(req, "tx_ptr", int'(tx_ptr), ptr);
    chk(req, "tx_src", int'(tx_src), NODE);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      chk(req, "tx_valid quiet", int'(tx_valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_evict = 1'b0;
    rx_valid = 1'b0; rx_type = '0; rx_src = '0; rx_dst = '0; rx_ptr = '0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "tx_valid", int'(tx_valid), 0);
    perm("R1", 0, 0, 0);

    // R2 read miss goes to memory
    cpu_rd = 1'b1;
    expect_tx("R2", T_MREQ, MEM, 0);
    perm("R2", 0, 0, 0);
    // R3 empty list: head, clean
    send("R3", T_MRSP, MEM, 0);
    perm("R3", 1, 0, 1);
    cpu_rd = 1'b0;

    // R5 attach from node 5 while head
    send("R5", T_ATT, 5, 0);
    expect_tx("R5", T_ATTR, 5, 0);
    perm("R5", 1, 0, 0);

    // R6 invalidate from head 5; down pointer is null
    send("R6", T_INV, 5, 0);
    expect_tx("R6", T_INVR, 5, 0);
    perm("R6", 0, 0, 0);
    cpu_rd = 1'b1;
    expect_tx("R6", T_MREQ, MEM, 0);

    // R4 join behind node 5
    send("R4", T_MRSP, MEM, 5);
    expect_tx("R4", T_ATT, 5, 0);
    perm("R4", 1, 0, 0);
    // R8 illegal invalidate while pending, then retry of attach
    send("R8", T_INV, 7, 0);
    expect_tx("R8", T_RETRY, 7, 0);
    send("R8", T_RETRY, 5, 0);
    expect_tx("R8", T_ATT, 5, 0);
    send("R4", T_ATTR, 5, 0);
    perm("R4", 1, 0, 1);
    cpu_rd = 1'b0;

    // R7 invalidate walk 5 -> 7 -> null
    cpu_wr = 1'b1;
    expect_tx("R7", T_INV, 5, 0);
    perm("R7", 1, 0, 1);
    send("R7", T_INVR, 5, 7);
    expect_tx("R7", T_INV, 7, 0);
    chk("R7", "wr_ok mid walk", int'(wr_ok), 0);
    send("R7", T_INVR, 7, 0);
    perm("R7", 1, 1, 1);
    chk("R14", "wr_ok with head", int'(wr_ok && head_o && rd_ok), 1);

    // R5 dirty head loses write to attacher 9; R9 writer then unlinks and rejoins
    send("R5", T_ATT, 9, 0);
    expect_tx("R5", T_ATTR, 9, 0);
    chk("R5", "wr_ok after attach", int'(wr_ok), 0);
    chk("R5", "head_o after attach", int'(head_o), 0);
    expect_tx("R9", T_SETDN, 9, 0);
    send("R9", T_UNLR, 9, 0);
    expect_tx("R9", T_MREQ, MEM, 0);
    send("R9", T_MRSP, MEM, 9);
    expect_tx("R9", T_ATT, 9, 0);
    send("R9", T_ATTR, 9, 0);
    expect_tx("R9", T_INV, 9, 0);
    send("R9", T_INVR, 9, 0);
    perm("R9", 1, 1, 1);

    // R7 clean head with no down neighbour: write granted without packets
    // (reached again below after eviction)

    // R10 dirty head eviction: write-back, then set-up to down neighbour (null after walk)
    cpu_wr = 1'b0;
    cpu_evict = 1'b1;
    expect_tx("R10", T_WB, MEM, 0);
    cpu_evict = 1'b0;
    perm("R10", 0, 0, 0);
    expect_quiet("R10", 2);

    // R12 packets for another node are ignored
    send("R12", T_INV, 5, 0, 3);
    expect_quiet("R12", 3);
    send("R12", T_MRSP, MEM, 0, 3);
    expect_quiet("R12", 2);
    perm("R12", 0, 0, 0);

    // R11 set-down updates down pointer; R10 eviction unlinks both sides
    cpu_rd = 1'b1;
    expect_tx("R10", T_MREQ, MEM, 0);
    send("R10", T_MRSP, MEM, 4);
    expect_tx("R10", T_ATT, 4, 0);
    send("R10", T_ATTR, 4, 0);
    cpu_rd = 1'b0;
    send("R11", T_ATT, 6, 0);
    expect_tx("R11", T_ATTR, 6, 0);
    send("R11", T_SETDN, 4, 8);
    expect_tx("R11", T_UNLR, 4, 0);
    perm("R11", 1, 0, 0);
    cpu_evict = 1'b1;
    expect_tx("R10", T_SETDN, 6, 8);
    cpu_evict = 1'b0;
    send("R10", T_UNLR, 6, 0);
    expect_tx("R10", T_SETUP, 8, 6);
    send("R10", T_UNLR, 8, 0);
    perm("R10", 0, 0, 0);

    // R11 set-up with null promotes a sharer; R8 retry of illegal invalidate at head
    cpu_rd = 1'b1;
    expect_tx("R11", T_MREQ, MEM, 0);
    send("R11", T_MRSP, MEM, 4);
    expect_tx("R11", T_ATT, 4, 0);
    send("R11", T_ATTR, 4, 0);
    cpu_rd = 1'b0;
    send("R11", T_ATT, 6, 0);
    expect_tx("R11", T_ATTR, 6, 0);
    send("R11", T_SETUP, 6, 0);
    expect_tx("R11", T_UNLR, 6, 0);
    perm("R11", 1, 0, 1);
    send("R8", T_INV, 2, 0);
    expect_tx("R8", T_RETRY, 2, 0);
    perm("R8", 1, 0, 1);

    // R7 walk from head with down neighbour 4, which returns null
    cpu_wr = 1'b1;
    expect_tx("R7", T_INV, 4, 0);
    send("R7", T_INVR, 4, 0);
    perm("R7", 1, 1, 1);
    // R10 dirty head with null neighbours: write-back only
    cpu_wr = 1'b0;
    cpu_evict = 1'b1;
    expect_tx("R10", T_WB, MEM, 0);
    cpu_evict = 1'b0;
    expect_quiet("R10", 2);
    perm("R10", 0, 0, 0);

    // R7 clean head without neighbours: write permitted without packets
    cpu_rd = 1'b1;
    expect_tx("R7", T_MREQ, MEM, 0);
    send("R7", T_MRSP, MEM, 0);
    cpu_rd = 1'b0;
    cpu_wr = 1'b1;
    @(negedge clk);
    perm("R7", 1, 1, 1);
    chk("R7", "no packet", int'(tx_valid), 0);
    cpu_wr = 1'b0;

    repeat (3) @(negedge clk);
    summary();
  end
endmodule